// File: doc/BRIEF.md
# Strap-Addressed Clock Configuration Target

This block is a two-wire serial bus target that holds one 8-bit control word for an audio clock generator. The word has no sub-address. A write is the target's address byte followed by one data byte. A read returns the control word with no pointer set beforehand. The target's own 7-bit bus address is decoded from two three-level strap inputs and latched in the first clock cycle after reset. It stays fixed until the next reset.

A mode input chooses where the clock-generator controls come from. In software mode they are the fields of the written control word. In hardware mode they are decoded directly from the strap pins and a three-level frequency-select pin. The bus side stays active in both modes. SDA is driven open-drain: the block only ever asserts a pull-low enable. SCL and SDA are sampled by the system clock through two-flop synchronisers, and the target never stretches the clock.

Three-level pins arrive encoded on two bits: 00 = low, 01 = high, 10 = open. The code 11 is read as open.

Top module: `strap_cfg_target`

## Requirements
- R1: After reset the control word is 0x00, every software-mode output is 0 and `sda_oe` is 0.
- R2: The bus address is latched from (`strap_a`, `strap_b`) right after reset, using this mapping (a/b): open/open 1100000, low/open 1100011, high/open 1100010, open/low 1100100, low/low 1101000, high/low 1110000, open/high 1110001, low/high 1110010, high/high 1110100. Changing the straps later does not change the address.
- R3: The target pulls SDA low in the ACK slot only when the 7 received address bits equal its latched address. Any other address gets no ACK and leaves the control word unchanged.
- R4: A write (R/W bit 0) stores the first data byte into the control word and ACKs it.
- R5: Data bytes after the first in a write are NACKed and do not change the control word.
- R6: A read (R/W bit 1) returns the control word MSB first. It keeps returning it after each controller ACK and stops driving after a controller NACK.
- R7: With `hw_mode` = 0 the outputs follow the control word: bit 7 `mclk_en`, bit 6 `clk_out2_en`, bit 5 `clk_out1_en`, bit 4 `rate_dbl`, bits 3:2 `scale_code`, bits 1:0 `fs_code`.
- R8: With `hw_mode` = 1, `mclk_en` is 1 when `strap_a` is high and 0 when it is low or open.
- R9: With `hw_mode` = 1, `strap_b` open enables both clock outputs, low enables only `clk_out1_en`, and high enables only `clk_out2_en`.
- R10: With `hw_mode` = 1, `fs_code` is 00 for `fsel` low, 01 for high and 10 for open. `rate_dbl` is 0 and `scale_code` is 00.
- R11: A START seen anywhere, including in the middle of a byte, drops any SDA drive and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain drive) |
| hw_mode | input | 1 | 0 = outputs from control word, 1 = outputs from pins |
| strap_a | input | 2 | Three-level strap A (address, MCLK in hardware mode) |
| strap_b | input | 2 | Three-level strap B (address, clock enables in hardware mode) |
| fsel | input | 2 | Three-level sampling-frequency select for hardware mode |
| mclk_en | output | 1 | Master clock enable |
| clk_out2_en | output | 1 | Clock output 2 enable |
| clk_out1_en | output | 1 | Clock output 1 enable |
| rate_dbl | output | 1 | 1 = doubled sampling rate |
| scale_code | output | 2 | Frequency-scaling code |
| fs_code | output | 2 | Sampling-frequency code |

## Verification
The assertions assume that SCL and SDA each stay level for several system clocks. They also assume the controller changes SDA only while SCL is low, except when it makes a START or STOP. Finally, they assume the controller never tries a START while the target holds SDA low. The bench drives every bus phase for six system clocks. It places each data change in the low half of SCL and issues a repeated START only in the middle of a write byte, when the target is not driving. Straps are changed only while the bus is idle.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int ADDR_W = 7;
  localparam int REG_W  = 8;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_HIGH = 2'b01;
  localparam logic [1:0] LVL_OPEN = 2'b10;

  typedef struct packed {
    logic       mclk;
    logic       clk2;
    logic       clk1;
    logic       dbl;
    logic [1:0] scale;
    logic [1:0] fs;
  } ctrl_t;

  // 11 is read as open
  function automatic logic is_open(input logic [1:0] p);
    return p[1];
  endfunction

  function automatic logic [ADDR_W-1:0] strap_addr(input logic [1:0] a,
                                                    input logic [1:0] b);
    logic [ADDR_W-1:0] r;
    if (is_open(b)) begin
      if (is_open(a))        r = 7'b1100000;
      else if (a == LVL_LOW) r = 7'b1100011;
      else                   r = 7'b1100010;
    end else if (b == LVL_LOW) begin
      if (is_open(a))        r = 7'b1100100;
      else if (a == LVL_LOW) r = 7'b1101000;
      else                   r = 7'b1110000;
    end else begin
      if (is_open(a))        r = 7'b1110001;
      else if (a == LVL_LOW) r = 7'b1110010;
      else                   r = 7'b1110100;
    end
    return r;
  endfunction

  function automatic ctrl_t pin_ctrl(input logic [1:0] a, input logic [1:0] b,
                                     input logic [1:0] f);
    ctrl_t c;
    c.mclk  = (a == LVL_HIGH);
    c.clk1  = is_open(b) || (b == LVL_LOW);
    c.clk2  = is_open(b) || (b == LVL_HIGH);
    c.dbl   = 1'b0;
    c.scale = 2'b00;
    if (is_open(f))        c.fs = 2'b10;
    else if (f == LVL_LOW) c.fs = 2'b00;
    else                   c.fs = 2'b01;
    return c;
  endfunction
endpackage

// File: rtl/strap_cfg_sync.sv
module strap_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[i] <= 1'b1;
          sda_pipe[i] <= 1'b1;
        end else if (i == 0) begin
          scl_pipe[i] <= scl_i;
          sda_pipe[i] <= sda_i;
        end else begin
          scl_pipe[i] <= scl_pipe[i-1];
          sda_pipe[i] <= sda_pipe[i-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/strap_cfg_engine.sv
module strap_cfg_engine
  import strap_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              sda_oe,
  output logic [REG_W-1:0]  ctrl_reg,
  output logic              addr_done,
  output logic              addr_hit,
  output logic              reg_we
);
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_END, S_ACK_A, S_WDATA, S_WDATA_END,
    S_WACK, S_RDATA, S_RACK, S_SKIP
  } st_e;

  localparam int CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(REG_W);

  st_e              st;
  logic [REG_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic             rd, first, mack;
  logic             bus_ev;
  logic [REG_W-1:0] wdata;

  assign bus_ev    = start_evt | stop_evt;
  assign addr_hit  = (sh[REG_W-1:1] == dev_addr);
  assign addr_done = (st == S_ADDR_END) && scl_fall && !bus_ev;
  assign wdata     = {sh[REG_W-2:0], sda_s};
  assign reg_we    = (st == S_WDATA) && scl_rise && (cnt == LAST_BIT) && first && !bus_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_reg <= '0;
    else if (reg_we) ctrl_reg <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cnt <= '0;
      rd <= 1'b0; first <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
    end else if (start_evt) begin
      st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      unique case (st)
        S_ADDR, S_WDATA: if (scl_rise) begin
          sh  <= wdata;
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BIT) st <= (st == S_ADDR) ? S_ADDR_END : S_WDATA_END;
        end
        S_ADDR_END: if (scl_fall) begin
          if (addr_hit) begin
            sda_oe <= 1'b1;
            rd     <= sh[0];
            st     <= S_ACK_A;
          end else st <= S_SKIP;
        end
        S_ACK_A: if (scl_fall) begin
          cnt   <= '0;
          first <= 1'b1;
          if (rd) begin
            sh     <= ctrl_reg;
            sda_oe <= ~ctrl_reg[REG_W-1];
            st     <= S_RDATA;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_WDATA;
          end
        end
        S_WDATA_END: if (scl_fall) begin
          sda_oe <= first;
          st     <= S_WACK;
        end
        S_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          first  <= 1'b0;
          cnt    <= '0;
          st     <= S_WDATA;
        end
        S_RDATA: begin
          if (scl_rise) cnt <= cnt + 1'b1;
          else if (scl_fall) begin
            if (cnt == ALL_BITS) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              sh     <= {sh[REG_W-2:0], 1'b0};
              sda_oe <= ~sh[REG_W-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              sh     <= ctrl_reg;
              sda_oe <= ~ctrl_reg[REG_W-1];
              cnt    <= '0;
              st     <= S_RDATA;
            end else st <= S_SKIP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/strap_cfg_outmux.sv
module strap_cfg_outmux
  import strap_cfg_pkg::*;
(
  input  logic             hw_mode,
  input  logic [REG_W-1:0] ctrl_reg,
  input  logic [1:0]       strap_a,
  input  logic [1:0]       strap_b,
  input  logic [1:0]       fsel,
  output ctrl_t            ctrl_out
);
  ctrl_t sw_ctrl, hw_ctrl;
  assign sw_ctrl  = ctrl_t'(ctrl_reg);
  assign hw_ctrl  = pin_ctrl(strap_a, strap_b, fsel);
  assign ctrl_out = hw_mode ? hw_ctrl : sw_ctrl;
endmodule

// File: rtl/strap_cfg_target.sv
module strap_cfg_target
  import strap_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       hw_mode,
  input  logic [1:0] strap_a,
  input  logic [1:0] strap_b,
  input  logic [1:0] fsel,
  output logic       mclk_en,
  output logic       clk_out2_en,
  output logic       clk_out1_en,
  output logic       rate_dbl,
  output logic [1:0] scale_code,
  output logic [1:0] fs_code
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic addr_done, addr_hit, reg_we, addr_valid;
  logic [ADDR_W-1:0] dev_addr;
  logic [REG_W-1:0]  ctrl_reg;
  ctrl_t             ctrl_out;

  // one-shot address capture after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      dev_addr   <= '0;
    end else if (!addr_valid) begin
      addr_valid <= 1'b1;
      dev_addr   <= strap_addr(strap_a, strap_b);
    end
  end

  strap_cfg_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  strap_cfg_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_addr(dev_addr), .sda_oe(sda_oe), .ctrl_reg(ctrl_reg),
    .addr_done(addr_done), .addr_hit(addr_hit), .reg_we(reg_we)
  );

  strap_cfg_outmux u_mux (
    .hw_mode(hw_mode), .ctrl_reg(ctrl_reg), .strap_a(strap_a),
    .strap_b(strap_b), .fsel(fsel), .ctrl_out(ctrl_out)
  );

  assign mclk_en     = ctrl_out.mclk;
  assign clk_out2_en = ctrl_out.clk2;
  assign clk_out1_en = ctrl_out.clk1;
  assign rate_dbl    = ctrl_out.dbl;
  assign scale_code  = ctrl_out.scale;
  assign fs_code     = ctrl_out.fs;
endmodule

// File: rtl/strap_cfg_target_chk.sv
module strap_cfg_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_mode,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       addr_done,
  input logic       addr_hit,
  input logic       reg_we,
  input logic       addr_valid,
  input logic [6:0] dev_addr,
  input logic [7:0] ctrl_reg,
  input logic       mclk_en,
  input logic       clk_out2_en,
  input logic       clk_out1_en,
  input logic       rate_dbl,
  input logic [1:0] scale_code,
  input logic [1:0] fs_code
);
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> $stable(dev_addr)); // R2
  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> !sda_oe); // R3
  AST_OWN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && addr_hit) |=> sda_oe); // R3
  AST_WORD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(ctrl_reg)); // R5
  AST_DRIVE_WHEN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R4
  AST_SW_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_mode |-> ({mclk_en, clk_out2_en, clk_out1_en, rate_dbl, scale_code, fs_code} == ctrl_reg)); // R7
  AST_HW_ONE_CLK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |-> (clk_out1_en || clk_out2_en)); // R9
  AST_HW_NO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |-> (!rate_dbl && scale_code == 2'b00 && fs_code != 2'b11)); // R10
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe); // R11
endmodule

bind strap_cfg_target strap_cfg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .addr_done(addr_done), .addr_hit(addr_hit),
  .reg_we(reg_we), .addr_valid(addr_valid), .dev_addr(dev_addr),
  .ctrl_reg(ctrl_reg), .mclk_en(mclk_en), .clk_out2_en(clk_out2_en),
  .clk_out1_en(clk_out1_en), .rate_dbl(rate_dbl), .scale_code(scale_code),
  .fs_code(fs_code)
);

// File: tb/strap_cfg_target_bench.sv
module strap_cfg_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, hw_mode = 1'b0;
  logic [1:0] strap_a = 2'b10, strap_b = 2'b10, fsel = 2'b00;
  logic sda_oe, mclk_en, clk_out2_en, clk_out1_en, rate_dbl;
  logic [1:0] scale_code, fs_code;
  wire  sda_line = !(m_low || sda_oe);
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  // index = b*3 + a, level index low=0 high=1 open=2
  logic [6:0] addr_tbl [0:8] = '{7'b1101000, 7'b1110000, 7'b1100100,
                                  7'b1110010, 7'b1110100, 7'b1110001,
                                  7'b1100011, 7'b1100010, 7'b1100000};

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_cfg_target u_strap_cfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .hw_mode(hw_mode), .strap_a(strap_a), .strap_b(strap_b), .fsel(fsel),
    .mclk_en(mclk_en), .clk_out2_en(clk_out2_en), .clk_out1_en(clk_out1_en),
    .rate_dbl(rate_dbl), .scale_code(scale_code), .fs_code(fs_code)
  );

  function automatic logic [7:0] outs();
    return {mclk_en, clk_out2_en, clk_out1_en, rate_dbl, scale_code, fs_code};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    m_low = !b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(!ack);
  endtask

  task automatic write_word(input logic [6:0] a, input logic [7:0] d,
                            output logic ack_a, output logic ack_d);
    bus_start();
    put_byte({a, 1'b0}, ack_a);
    if (ack_a) put_byte(d, ack_d); else ack_d = 1'b0;
    bus_stop();
  endtask

  task automatic read_word(input logic [6:0] a, output logic ack_a, output logic [7:0] d);
    bus_start();
    put_byte({a, 1'b1}, ack_a);
    if (ack_a) get_byte(1'b0, d); else d = 8'hxx;
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {24'd0, outs()}, 32'h00);
    chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_write_fields();
    logic aa, ad;
    write_word(addr_tbl[8], 8'hA5, aa, ad);
    chk("R4 address ack", {31'd0, aa}, 1);
    chk("R4 data ack", {31'd0, ad}, 1);
    @(negedge clk);
    chk("R7 mclk bit7", {31'd0, mclk_en}, 1);
    chk("R7 clk2 bit6", {31'd0, clk_out2_en}, 0);
    chk("R7 clk1 bit5", {31'd0, clk_out1_en}, 1);
    chk("R7 dbl bit4", {31'd0, rate_dbl}, 0);
    chk("R7 scale bits3:2", {30'd0, scale_code}, 2'b01);
    chk("R7 fs bits1:0", {30'd0, fs_code}, 2'b01);
  endtask

  task automatic t_read_repeat();
    logic aa; logic [7:0] d0, d1;
    bus_start();
    put_byte({addr_tbl[8], 1'b1}, aa);
    get_byte(1'b1, d0);
    get_byte(1'b0, d1);
    chk("R6 read ack", {31'd0, aa}, 1);
    chk("R6 first byte", {24'd0, d0}, 8'hA5);
    chk("R6 repeated byte", {24'd0, d1}, 8'hA5);
    chk("R6 released after nack", {31'd0, sda_oe}, 0);
    bus_stop();
  endtask

  task automatic t_foreign();
    logic aa, ad; logic [7:0] d;
    write_word(7'b1011011, 8'h3C, aa, ad);
    chk("R3 foreign address nack", {31'd0, aa}, 0);
    read_word(addr_tbl[8], aa, d);
    chk("R3 word unchanged", {24'd0, d}, 8'hA5);
  endtask

  task automatic t_extra_bytes();
    logic aa, a1, a2;
    bus_start();
    put_byte({addr_tbl[8], 1'b0}, aa);
    put_byte(8'h5A, a1);
    put_byte(8'hFF, a2);
    bus_stop();
    chk("R5 first data ack", {31'd0, a1}, 1);
    chk("R5 second data nack", {31'd0, a2}, 0);
    chk("R5 word keeps first byte", {24'd0, outs()}, 8'h5A);
  endtask

  task automatic t_restart();
    logic aa, ad;
    bus_start();
    put_byte({addr_tbl[8], 1'b0}, aa);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    put_byte({addr_tbl[8], 1'b0}, aa);
    put_byte(8'h3C, ad);
    bus_stop();
    chk("R11 restart address ack", {31'd0, aa}, 1);
    chk("R11 restart data ack", {31'd0, ad}, 1);
    chk("R11 word after restart", {24'd0, outs()}, 8'h3C);
  endtask

  task automatic t_strap_hold();
    logic aa, ad;
    strap_a = 2'b00; strap_b = 2'b00;
    repeat (4) @(negedge clk);
    write_word(addr_tbl[0], 8'h11, aa, ad);
    chk("R2 new straps ignored until reset", {31'd0, aa}, 0);
    write_word(addr_tbl[8], 8'h22, aa, ad);
    chk("R2 latched address kept", {31'd0, aa}, 1);
  endtask

  task automatic t_strap_table();
    logic aa, ad;
    for (int b = 0; b < 3; b++) begin
      for (int a = 0; a < 3; a++) begin
        strap_a = 2'(a); strap_b = 2'(b);
        do_reset();
        write_word(addr_tbl[b*3+a], 8'h60, aa, ad);
        chk($sformatf("R2 address a=%0d b=%0d", a, b), {31'd0, aa}, 1);
      end
    end
    strap_a = 2'b11; strap_b = 2'b11;
    do_reset();
    write_word(addr_tbl[8], 8'h00, aa, ad);
    chk("R2 code 11 read as open", {31'd0, aa}, 1);
  endtask

  task automatic t_hw_mode();
    hw_mode = 1'b1;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int f = 0; f < 3; f++) begin
          strap_a = 2'(a); strap_b = 2'(b); fsel = 2'(f);
          @(negedge clk);
          chk("R8 hw mclk", {31'd0, mclk_en}, (a == 1) ? 1 : 0);
          chk("R9 hw clk1", {31'd0, clk_out1_en}, (b != 1) ? 1 : 0);
          chk("R9 hw clk2", {31'd0, clk_out2_en}, (b != 0) ? 1 : 0);
          chk("R10 hw fs", {30'd0, fs_code}, f);
          chk("R10 hw dbl/scale", {29'd0, rate_dbl, scale_code}, 0);
        end
    hw_mode = 1'b0;
  endtask

  initial begin
    do_reset();
    t_reset();
    t_write_fields();
    t_read_repeat();
    t_foreign();
    t_extra_bytes();
    t_restart();
    t_strap_hold();
    t_strap_table();
    t_hw_mode();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule